// File: doc/BRIEF.md
# Pass-Through Local Transfer Agent

This block sits on the local side of a PCI target bridge and services pass-through accesses that the bridge has posted. It watches the bridge's status outputs: an active-low attention line, an active-low burst flag, a direction bit, a two-bit region number and active-low byte enables. On each new access it latches the status and reads the captured PCI address through a dedicated address strobe. It then moves one datum per local data phase through the bridge's data register. When the PCI side writes, the agent reads the register. When the PCI side reads, the agent writes it.

A local data phase closes only on a clock edge where attention and the agent's active-low ready are both low. Local wait states come from a wait-state setting. Stalls by the PCI initiator appear as attention going high. The two are handled separately. Every finished phase is logged with its address, data, region and byte enables in a small ring buffer, which a readback port exposes. The local address starts at the captured PCI address and advances by one 32-bit word per phase.

Top module: `pt_local_agent`

## Requirements
- R1: While reset is held, the address strobe, select, read strobe, write strobe and ready outputs are all high, the local byte enables are 4'hF, the offset is 0 and the data output is 0.
- R2: In the idle state, a rising edge with attention low latches region, direction and byte enables. For exactly the next clock the address strobe is low. During that clock and every data-state clock, select is low, the local byte enables are 4'h0 and the offset output is 8'h2C. In idle, select is high and the offset is 0.
- R3: The value on the data input at the end of the address-strobe clock becomes the starting local address of the access.
- R4: In the data state, a direction bit of 1 (PCI write) holds the read strobe low for every clock. A direction bit of 0 (PCI read) holds the write strobe low for every clock and drives the current local address on the data output. The address strobe, read strobe and write strobe are never low together in pairs.
- R5: With a wait setting W (0 to 3), ready stays high for the first W clocks of every data phase and then stays low until the phase closes.
- R6: A phase closes on an edge where attention and ready are both low. The closing edge stores region, byte enables, local address and datum in the next of 16 buffer slots, with wraparound. The datum is the data input for a PCI write and the local address for a PCI read. The local address then grows by 4.
- R7: An edge with attention high stores nothing and leaves the local address unchanged, while the wait count keeps running.
- R8: In the data state, an edge where both attention and burst are high ends the access. Select returns high, and an edge with attention low one clock later starts a new access.
- R9: The readback port combinationally shows the address, data, region and byte enables of the slot that the readback index selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| att_n_i | input | 1 | Bridge attention, active low |
| burst_n_i | input | 1 | Bridge burst flag, active low |
| wr_st_i | input | 1 | Direction: 1 = PCI write, 0 = PCI read |
| region_i | input | 2 | Pass-through region number |
| be_n_i | input | 4 | PCI byte enables, active low |
| wait_cfg_i | input | 2 | Local wait states per phase |
| din_i | input | 32 | Data from the bridge |
| adr_n_o | output | 1 | Address-register read strobe, active low |
| sel_n_o | output | 1 | Register select, active low |
| rd_n_o | output | 1 | Data-register read strobe, active low |
| wr_n_o | output | 1 | Data-register write strobe, active low |
| lbe_n_o | output | 4 | Local byte enables, active low |
| ofs_o | output | 8 | Local register offset |
| dout_o | output | 32 | Data to the bridge |
| rdy_n_o | output | 1 | Local ready, active low |
| rb_idx_i | input | 4 | Readback slot index |
| rb_addr_o | output | 32 | Readback address |
| rb_data_o | output | 32 | Readback data |
| rb_region_o | output | 2 | Readback region |
| rb_be_n_o | output | 4 | Readback byte enables |

## Verification
The assertions assume the wait setting changes only while the agent is idle. They also assume the bridge never raises attention and burst together before the last datum has been taken. The bench bridge model meets both conditions. It writes the wait setting only between accesses, once the reference model shows idle. It inserts initiator stalls only while more than one datum remains, and it keeps burst low during those stalls.

// File: rtl/pt_pkg.sv
package pt_pkg;
    parameter int PT_DW = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } pt_state_e;

    typedef struct packed {
        logic [1:0]       region;
        logic [3:0]       be_n;
        logic [PT_DW-1:0] addr;
        logic [PT_DW-1:0] data;
    } pt_entry_s;
endpackage

// File: rtl/pt_wait_ctr.sv
module pt_wait_ctr #(
    parameter int WCW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic [WCW-1:0] cfg_i,
    output logic           ready_o
);
    typedef struct packed {
        logic [WCW-1:0] cnt;
    } wt_s;

    wt_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clr_i)
            nxt_d.cnt = '0;
        else if (cur_q.cnt < cfg_i)
            nxt_d.cnt = cur_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ready_o = (cur_q.cnt >= cfg_i);

    // R5: a fresh phase never starts ready unless no wait states are set
    p_wait_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cfg_i == '0) || !ready_o);
endmodule

// File: rtl/pt_cap_buf.sv
module pt_cap_buf import pt_pkg::*; #(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we_i,
    input  pt_entry_s ent_i,
    input  logic [IW-1:0] rb_idx_i,
    output pt_entry_s rb_o
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } bp_s;

    bp_s ptr_q, ptr_d;
    pt_entry_s slots [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (we_i) ptr_d.ptr = ptr_q.ptr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        pt_entry_s slot_d, slot_q;
        always_comb begin
            slot_d = slot_q;
            if (we_i && ptr_q.ptr == IW'(g)) slot_d = ent_i;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end
        assign slots[g] = slot_q;
    end

    assign rb_o = slots[rb_idx_i];
endmodule

// File: rtl/pt_local_agent.sv
module pt_local_agent import pt_pkg::*; #(
    parameter int          DEPTH    = 16,
    parameter int          WCW      = 2,
    parameter logic [7:0]  DATA_OFS = 8'h2C,
    localparam int         IW       = $clog2(DEPTH),
    localparam int         DW       = PT_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          att_n_i,
    input  logic          burst_n_i,
    input  logic          wr_st_i,
    input  logic [1:0]    region_i,
    input  logic [3:0]    be_n_i,
    input  logic [WCW-1:0] wait_cfg_i,
    input  logic [DW-1:0] din_i,
    output logic          adr_n_o,
    output logic          sel_n_o,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic [3:0]    lbe_n_o,
    output logic [7:0]    ofs_o,
    output logic [DW-1:0] dout_o,
    output logic          rdy_n_o,
    input  logic [IW-1:0] rb_idx_i,
    output logic [DW-1:0] rb_addr_o,
    output logic [DW-1:0] rb_data_o,
    output logic [1:0]    rb_region_o,
    output logic [3:0]    rb_be_n_o
);
    typedef struct packed {
        pt_state_e     st;
        logic [1:0]    region;
        logic          wr;
        logic [3:0]    be_n;
        logic [DW-1:0] addr;
    } ag_s;

    ag_s       cur_q, nxt_d;
    logic      phase_done;
    logic      wt_ready;
    logic      wt_clr;
    pt_entry_s ent;
    pt_entry_s rb_ent;

    always_comb begin
        nxt_d      = cur_q;
        phase_done = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (!att_n_i) begin
                    nxt_d.region = region_i;
                    nxt_d.wr     = wr_st_i;
                    nxt_d.be_n   = be_n_i;
                    nxt_d.st     = ST_ADDR;
                end
            end
            ST_ADDR: begin
                nxt_d.addr = din_i;
                nxt_d.st   = ST_DATA;
            end
            ST_DATA: begin
                if (!att_n_i && wt_ready) begin
                    phase_done = 1'b1;
                    nxt_d.addr = cur_q.addr + DW'(4);
                end else if (att_n_i && burst_n_i) begin
                    nxt_d.st = ST_IDLE;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE, default: '0};
        else        cur_q <= nxt_d;
    end

    assign wt_clr = (cur_q.st != ST_DATA) || phase_done;

    pt_wait_ctr #(.WCW(WCW)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (wt_clr),
        .cfg_i   (wait_cfg_i),
        .ready_o (wt_ready)
    );

    always_comb begin
        ent.region = cur_q.region;
        ent.be_n   = cur_q.be_n;
        ent.addr   = cur_q.addr;
        ent.data   = cur_q.wr ? din_i : cur_q.addr;
    end

    pt_cap_buf #(.DEPTH(DEPTH)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (phase_done),
        .ent_i    (ent),
        .rb_idx_i (rb_idx_i),
        .rb_o     (rb_ent)
    );

    always_comb begin
        adr_n_o = !(cur_q.st == ST_ADDR);
        sel_n_o = (cur_q.st == ST_IDLE);
        lbe_n_o = (cur_q.st == ST_IDLE) ? 4'hF : 4'h0;
        ofs_o   = (cur_q.st == ST_IDLE) ? 8'h00 : DATA_OFS;
        rd_n_o  = !((cur_q.st == ST_DATA) && cur_q.wr);
        wr_n_o  = !((cur_q.st == ST_DATA) && !cur_q.wr);
        dout_o  = wr_n_o ? '0 : cur_q.addr;
        rdy_n_o = !((cur_q.st == ST_DATA) && wt_ready);
    end

    assign rb_addr_o   = rb_ent.addr;
    assign rb_data_o   = rb_ent.data;
    assign rb_region_o = rb_ent.region;
    assign rb_be_n_o   = rb_ent.be_n;

    // R2: the address read lasts one clock and is followed by data-register access
    p_addr_then_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adr_n_o |=> adr_n_o && !sel_n_o);

    // R2: whenever select is low, the offset points at the data register
    p_sel_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n_o |-> (ofs_o == DATA_OFS) && (lbe_n_o == 4'h0));

    // R4: at most one strobe is active
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!adr_n_o, !rd_n_o, !wr_n_o}) <= 1);

    // R7: an edge without attention leaves the local address alone
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_DATA && att_n_i) |=> $stable(cur_q.addr));

    // R8: attention and burst both high in the data state end the access
    p_access_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o || !wr_n_o) && att_n_i && burst_n_i |=> sel_n_o && rdy_n_o);
endmodule

// File: tb/pt_local_agent_test.sv
`timescale 1ns/1ps
module pt_local_agent_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        att_n = 1'b1, burst_n = 1'b1, wr_st = 1'b0;
    logic [1:0]  region = '0;
    logic [3:0]  be_n = 4'hF;
    logic [1:0]  wcfg = '0;
    logic [31:0] din;
    logic        adr_n, sel_n, rd_n, wr_n, rdy_n;
    logic [3:0]  lbe_n;
    logic [7:0]  ofs;
    logic [31:0] dout;
    logic [3:0]  rb_idx = '0;
    logic [31:0] rb_addr, rb_data;
    logic [1:0]  rb_region;
    logic [3:0]  rb_be_n;

    always #2.5 clk = ~clk;

    pt_local_agent uut (
        .clk(clk), .rst_n(rst_n), .att_n_i(att_n), .burst_n_i(burst_n),
        .wr_st_i(wr_st), .region_i(region), .be_n_i(be_n), .wait_cfg_i(wcfg),
        .din_i(din), .adr_n_o(adr_n), .sel_n_o(sel_n), .rd_n_o(rd_n),
        .wr_n_o(wr_n), .lbe_n_o(lbe_n), .ofs_o(ofs), .dout_o(dout),
        .rdy_n_o(rdy_n), .rb_idx_i(rb_idx), .rb_addr_o(rb_addr),
        .rb_data_o(rb_data), .rb_region_o(rb_region), .rb_be_n_o(rb_be_n)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // bridge model
    int          remaining = 0, idx = 0, cyc = 0;
    bit          stall_en = 0;
    logic [31:0] base = '0;

    function automatic logic [31:0] dat(input int i);
        return base ^ (32'h5A5A0000 + 32'(i) * 32'h00000111);
    endfunction

    assign din = !adr_n ? base : (!rd_n ? dat(idx) : 32'h0);

    // reference model
    int          m_st = 0, m_wait = 0, m_ptr = 0;
    logic [31:0] m_addr = '0;
    bit          m_wr = 0;
    logic [1:0]  m_reg = '0;
    logic [3:0]  m_be = '0;
    logic [31:0] e_addr [16], e_data [16];
    logic [1:0]  e_reg [16];
    logic [3:0]  e_be [16];
    bit          e_val [16];

    always @(posedge clk) begin
        if (rst_n) begin
            cyc++;
            case (m_st)
                0: if (!att_n) begin
                       m_reg = region; m_wr = wr_st; m_be = be_n; m_st = 1;
                   end
                1: begin m_addr = base; m_st = 2; m_wait = 0; end
                default: begin
                    if (!att_n && m_wait >= int'(wcfg)) begin
                        e_addr[m_ptr] = m_addr;
                        e_data[m_ptr] = m_wr ? dat(idx) : m_addr;
                        e_reg[m_ptr]  = m_reg;
                        e_be[m_ptr]   = m_be;
                        e_val[m_ptr]  = 1;
                        m_ptr = (m_ptr + 1) % 16;
                        m_addr = m_addr + 4;
                        m_wait = 0;
                    end else if (att_n && burst_n) begin
                        m_st = 0;
                    end else if (m_wait < int'(wcfg)) begin
                        m_wait++;
                    end
                end
            endcase
            if (!att_n && !rdy_n) begin
                remaining <= remaining - 1;
                idx <= idx + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(adr_n == (m_st != 1), "R2", "adr_n", 32'(adr_n), 32'(m_st != 1));
            chk(sel_n == (m_st == 0), (m_st == 0) ? "R8" : "R2", "sel_n",
                32'(sel_n), 32'(m_st == 0));
            chk(ofs == ((m_st == 0) ? 8'h00 : 8'h2C), "R2", "offset",
                32'(ofs), (m_st == 0) ? 32'h0 : 32'h2C);
            chk(lbe_n == ((m_st == 0) ? 4'hF : 4'h0), "R2", "lbe_n",
                32'(lbe_n), (m_st == 0) ? 32'hF : 32'h0);
            chk(rd_n == !(m_st == 2 && m_wr), "R4", "rd_n",
                32'(rd_n), 32'(!(m_st == 2 && m_wr)));
            chk(wr_n == !(m_st == 2 && !m_wr), "R4", "wr_n",
                32'(wr_n), 32'(!(m_st == 2 && !m_wr)));
            if (m_st == 2 && !m_wr)
                chk(dout == m_addr, "R4", "dout", dout, m_addr);
            chk(rdy_n == !(m_st == 2 && m_wait >= int'(wcfg)), "R5", "rdy_n",
                32'(rdy_n), 32'(!(m_st == 2 && m_wait >= int'(wcfg))));
            if (remaining > 0) begin
                att_n   <= stall_en && remaining > 1 && (cyc % 4 == 1);
                burst_n <= !(remaining > 1);
            end else begin
                att_n   <= 1'b1;
                burst_n <= 1'b1;
            end
        end
    end

    task automatic access(input logic [1:0] r, input bit w, input logic [3:0] b,
                          input logic [31:0] a, input int n, input logic [1:0] ws,
                          input bit st);
        while (m_st != 0 || remaining != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        #1;
        region = r; wr_st = w; be_n = b; base = a; wcfg = ws;
        stall_en = st; idx = 0; remaining = n;
        @(posedge clk);
        while (m_st != 0 || remaining != 0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) e_val[i] = 0;
        #12;
        // R1: outputs during reset
        chk(adr_n && sel_n && rd_n && wr_n && rdy_n, "R1", "strobes",
            {27'h0, adr_n, sel_n, rd_n, wr_n, rdy_n}, 32'h1F);
        chk(lbe_n == 4'hF && ofs == 8'h00 && dout == 32'h0, "R1", "bus idle",
            {20'h0, lbe_n, ofs}, 32'h00F00);
        @(negedge clk);
        rst_n = 1'b1;
        access(2'b01, 1'b1, 4'h0, 32'h0000_1000, 3, 2'd0, 1'b0);
        access(2'b10, 1'b0, 4'h0, 32'h0000_2040, 4, 2'd2, 1'b1);
        access(2'b11, 1'b1, 4'h3, 32'h8000_0100, 5, 2'd1, 1'b1);
        access(2'b00, 1'b0, 4'hC, 32'h0000_3000, 1, 2'd3, 1'b0);
        access(2'b01, 1'b1, 4'h0, 32'h0000_4400, 6, 2'd0, 1'b1);
        // 19 phases in total: slots 0..2 hold the last three (R6 wraparound)
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            if (e_val[i]) begin
                rb_idx = 4'(i);
                #0.5;
                chk(rb_addr == e_addr[i], "R3", "slot addr", rb_addr, e_addr[i]);
                chk(rb_data == e_data[i], "R6 R7", "slot data", rb_data, e_data[i]);
                chk(rb_region == e_reg[i], "R9", "slot region",
                    32'(rb_region), 32'(e_reg[i]));
                chk(rb_be_n == e_be[i], "R9", "slot be_n",
                    32'(rb_be_n), 32'(e_be[i]));
            end
        end
        chk(m_ptr == 3, "R6", "phase count mod 16", 32'(m_ptr), 32'd3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule